// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns a 32-bit IEEE-754 single-precision operand into a fixed-point integer. The integer is either 16 or 32 bits wide, signed or unsigned, with a selectable number of fraction bits. The operand is scaled by two raised to the fraction count and then rounded to an integer under one of five rounding policies. Results that do not fit the selected range saturate and raise an invalid flag. Rounding that loses information raises an inexact flag.

A conversion is requested by pulsing `in_valid` with the operand and its controls. The result and both flags appear on the registered outputs one clock later, together with `out_valid`. There is no back-pressure, and a new request may be issued on every cycle.

Top module: `f2x_convert`

## Requirements
- R1: On reset all outputs are zero. `out_valid` is high exactly in the cycle after `in_valid` was high. While `in_valid` stays low, the result and flags hold their last values.
- R2: The rounding code `in_rmode` selects the rounding policy: 0 nearest with ties to even, 1 toward +infinity, 2 toward -infinity, 3 toward zero, 4 nearest with ties away from zero. Codes 5, 6 and 7 behave as toward zero.
- R3: Before rounding, the operand is multiplied by 2^`in_fbits`. A fraction count larger than the selected width (16 or 32) is treated as equal to that width.
- R4: In code 4, a scaled value whose fraction is exactly one half rounds away from zero, for both positive and negative operands.
- R5: `out_inexact` is 1 when the rounded integer differs from the scaled operand and the result is in range. An exact conversion gives 0.
- R6: In signed mode, a rounded value above 2^(W-1)-1 saturates to 2^(W-1)-1, and one below -2^(W-1) saturates to -2^(W-1). Either case raises `out_invalid`.
- R7: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with `out_invalid`. A negative operand that rounds to zero gives 0 with no invalid flag. A value above 2^W-1 gives all ones in the W result bits with `out_invalid`.
- R8: A NaN operand gives 0 with `out_invalid`. An infinite operand saturates to the bound of its sign with `out_invalid`; for unsigned mode and -infinity that bound is 0.
- R9: An operand with exponent field zero (zero or subnormal) is treated as exact zero: result 0, no flags.
- R10: For 16-bit results (`in_wide`=0), the value sits in result bits [15:0] in two's complement, and bits [31:16] are zero.
- R11: `out_invalid` and `out_inexact` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request strobe |
| in_operand | input | 32 | Single-precision operand bits |
| in_signed | input | 1 | 1 selects a signed result, 0 unsigned |
| in_wide | input | 1 | 1 selects a 32-bit result, 0 a 16-bit result |
| in_fbits | input | 6 | Number of fraction bits in the result |
| in_rmode | input | 3 | Rounding code |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_result | output | 32 | Fixed-point result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The assertions check several properties on every cycle: the one-cycle request-to-result timing, that the outputs hold between requests, that the two flags are mutually exclusive, and that NaN and zero-exponent operands produce their fixed responses. They also check that 16-bit results leave the upper half clear. The numeric outcome of each rounding code, the tie cases, the fraction scaling and its clamp, and the exact saturation bounds for every width and sign combination depend on particular operand values. Only the bench's directed scenarios can show those, by comparing against hand-derived expectations.

// File: rtl/f2x_pkg.sv
package f2x_pkg;
    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int EXP_BIAS = 127;
    localparam int SIG_W    = MAN_W + 1;
    localparam int SHIFT_BIAS = EXP_BIAS + MAN_W;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_UP        = 3'd1,
        RM_DOWN      = 3'd2,
        RM_ZERO      = 3'd3,
        RM_NEAR_AWAY = 3'd4
    } rmode_e;
endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
    import f2x_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int FB_W  = 6
) (
    input  logic [FP_W-1:0]  operand,
    input  logic [FB_W-1:0]  fbits,
    output logic             is_nan,
    output logic             is_inf,
    output logic             is_zero,
    output logic             is_neg,
    output logic             is_huge,
    output logic [OUT_W-1:0] ipart,
    output logic             guard,
    output logic             sticky
);
    localparam int TAIL_W  = SIG_W + 1;
    localparam int WIDE_W  = SIG_W + TAIL_W;
    localparam int LSH_MAX = OUT_W - SIG_W;
    localparam int S_W     = 12;

    logic [EXP_W-1:0]  exp_f;
    logic [MAN_W-1:0]  frac_f;
    logic [SIG_W-1:0]  sig;
    logic signed [S_W-1:0] shamt;
    logic [S_W-1:0]    rsh;
    logic [WIDE_W-1:0] wide_v;

    always_comb begin
        exp_f   = operand[FP_W-2 -: EXP_W];
        frac_f  = operand[MAN_W-1:0];
        sig     = {1'b1, frac_f};
        is_neg  = operand[FP_W-1];
        is_zero = (exp_f == '0);
        is_nan  = (exp_f == '1) && (frac_f != '0);
        is_inf  = (exp_f == '1) && (frac_f == '0);
        shamt   = $signed({{(S_W-EXP_W){1'b0}}, exp_f})
                + $signed({{(S_W-FB_W){1'b0}}, fbits})
                - $signed(S_W'(SHIFT_BIAS));
        is_huge = shamt > $signed(S_W'(LSH_MAX));
        rsh     = S_W'(-shamt);
        wide_v  = '0;
        ipart   = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        if (shamt >= 0) begin
            ipart = OUT_W'(sig) << shamt[5:0];
        end else if (rsh > S_W'(TAIL_W)) begin
            sticky = 1'b1;
        end else begin
            wide_v = {sig, {TAIL_W{1'b0}}} >> rsh;
            ipart  = OUT_W'(wide_v[WIDE_W-1:TAIL_W]);
            guard  = wide_v[TAIL_W-1];
            sticky = |wide_v[TAIL_W-2:0];
        end
    end
endmodule

// File: rtl/f2x_round.sv
module f2x_round
    import f2x_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic [2:0]     rmode,
    input  logic           neg,
    input  logic [OUT_W-1:0] ipart,
    input  logic           guard,
    input  logic           sticky,
    output logic [OUT_W:0] mag,
    output logic           lost
);
    logic incr;

    always_comb begin
        lost = guard | sticky;
        unique case (rmode_e'(rmode))
            RM_NEAR_EVEN: incr = guard & (sticky | ipart[0]);
            RM_UP:        incr = ~neg & lost;
            RM_DOWN:      incr = neg & lost;
            RM_NEAR_AWAY: incr = guard;
            default:      incr = 1'b0;
        endcase
        mag = {1'b0, ipart} + {{OUT_W{1'b0}}, incr};
    end
endmodule

// File: rtl/f2x_limit.sv
module f2x_limit #(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             sgn,
    input  logic             wide,
    input  logic             neg,
    input  logic             huge,
    input  logic             nan,
    input  logic             inf,
    input  logic             zero,
    input  logic [OUT_W:0]   mag,
    input  logic             lost,
    output logic [OUT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [OUT_W:0] ONE = (OUT_W+1)'(1);

    logic [OUT_W:0]   pos_lim;
    logic [OUT_W:0]   neg_lim;
    logic [OUT_W-1:0] wmask;
    logic [OUT_W:0]   twos;
    logic             over;

    always_comb begin
        wmask   = wide ? '1 : OUT_W'({HALF_W{1'b1}});
        neg_lim = wide ? (ONE << (OUT_W-1)) : (ONE << (HALF_W-1));
        if (sgn) pos_lim = neg_lim - ONE;
        else     pos_lim = wide ? ((ONE << OUT_W) - ONE) : ((ONE << HALF_W) - ONE);
        over    = inf | huge;
        twos    = neg ? (~mag + ONE) : mag;
        result  = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (zero) begin
            result = '0;
        end else if (nan) begin
            invalid = 1'b1;
        end else if (!sgn && neg && (over || mag != '0)) begin
            invalid = 1'b1;
        end else if (!neg && (over || mag > pos_lim)) begin
            result  = OUT_W'(pos_lim);
            invalid = 1'b1;
        end else if (neg && (over || mag > neg_lim)) begin
            result  = OUT_W'(neg_lim);
            invalid = 1'b1;
        end else begin
            result  = OUT_W'(twos) & wmask;
            inexact = lost;
        end
    end
endmodule

// File: rtl/f2x_convert.sv
module f2x_convert
    import f2x_pkg::*;
#(
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16,
    parameter int FB_W   = $clog2(OUT_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    input  logic             in_signed,
    input  logic             in_wide,
    input  logic [FB_W-1:0]  in_fbits,
    input  logic [2:0]       in_rmode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_inexact
);
    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] result;
        logic             invalid;
        logic             inexact;
    } out_t;

    out_t state_d, state_q;

    logic [FB_W-1:0]  fb_lim, fb_eff;
    logic             nan_w, inf_w, zero_w, neg_w, huge_w, guard_w, sticky_w, lost_w;
    logic [OUT_W-1:0] ipart_w;
    logic [OUT_W:0]   mag_w;
    logic [OUT_W-1:0] res_w;
    logic             inv_w, inx_w;

    always_comb begin
        fb_lim = in_wide ? FB_W'(OUT_W) : FB_W'(HALF_W);
        fb_eff = (in_fbits > fb_lim) ? fb_lim : in_fbits;
    end

    f2x_unpack #(.OUT_W(OUT_W), .FB_W(FB_W)) u_unpack (
        .operand (in_operand),
        .fbits   (fb_eff),
        .is_nan  (nan_w),
        .is_inf  (inf_w),
        .is_zero (zero_w),
        .is_neg  (neg_w),
        .is_huge (huge_w),
        .ipart   (ipart_w),
        .guard   (guard_w),
        .sticky  (sticky_w)
    );

    f2x_round #(.OUT_W(OUT_W)) u_round (
        .rmode  (in_rmode),
        .neg    (neg_w),
        .ipart  (ipart_w),
        .guard  (guard_w),
        .sticky (sticky_w),
        .mag    (mag_w),
        .lost   (lost_w)
    );

    f2x_limit #(.OUT_W(OUT_W), .HALF_W(HALF_W)) u_limit (
        .sgn     (in_signed),
        .wide    (in_wide),
        .neg     (neg_w),
        .huge    (huge_w),
        .nan     (nan_w),
        .inf     (inf_w),
        .zero    (zero_w),
        .mag     (mag_w),
        .lost    (lost_w),
        .result  (res_w),
        .invalid (inv_w),
        .inexact (inx_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.result  = res_w;
            state_d.invalid = inv_w;
            state_d.inexact = inx_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_result  = state_q.result;
    assign out_invalid = state_q.invalid;
    assign out_inexact = state_q.inexact;

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)
                       && $stable(out_invalid) && $stable(out_inexact)));
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
    a_r8_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nan_w) |=> (out_result == '0 && out_invalid));
    a_r9_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_w) |=> (out_result == '0 && !out_invalid && !out_inexact));
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> (out_result[OUT_W-1:HALF_W] == '0));
endmodule

// File: tb/test_f2x_convert.sv
`timescale 1ns/1ps
module test_f2x_convert;
    typedef struct {
        logic [31:0] res;
        logic        inv;
        logic        inx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        in_signed = 1'b0;
    logic        in_wide = 1'b0;
    logic [5:0]  in_fbits = '0;
    logic [2:0]  in_rmode = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] last_res = '0;

    always #2.5 clk = ~clk;

    f2x_convert i_f2x_convert (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_signed   (in_signed),
        .in_wide     (in_wide),
        .in_fbits    (in_fbits),
        .in_rmode    (in_rmode),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual {res,inv,inx}=%h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(input string tag, input logic sgn, input logic wide,
                         input logic [5:0] fb, input logic [2:0] rm,
                         input logic [31:0] op, input logic [31:0] res,
                         input logic inv, input logic inx);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_signed  = sgn;
        in_wide    = wide;
        in_fbits   = fb;
        in_rmode   = rm;
        e.res = res; e.inv = inv; e.inx = inx; e.tag = tag;
        sb.push_back(e);
        last_res = res;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected out_valid", 34'd1, 34'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {out_result, out_invalid, out_inexact}, {e.res, e.inv, e.inx});
            end
        end
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {out_result, out_invalid, out_inexact}, 34'd0);
        check("R1 reset valid", {33'd0, out_valid}, 34'd0);
        rst_n = 1'b1;

        // sgn wide fb rm operand  result inv inx
        drive("R2 even 2.5",     1, 1, 0, 0, 32'h40200000, 32'h00000002, 0, 1);
        drive("R2 even 3.5",     1, 1, 0, 0, 32'h40600000, 32'h00000004, 0, 1);
        drive("R4 away 2.5",     1, 1, 0, 4, 32'h40200000, 32'h00000003, 0, 1);
        drive("R4 away -2.5",    1, 1, 0, 4, 32'hC0200000, 32'hFFFFFFFD, 0, 1);
        drive("R2 up 1.5",       1, 1, 0, 1, 32'h3FC00000, 32'h00000002, 0, 1);
        drive("R2 up -1.25",     1, 1, 0, 1, 32'hBFA00000, 32'hFFFFFFFF, 0, 1);
        drive("R2 down 1.5",     1, 1, 0, 2, 32'h3FC00000, 32'h00000001, 0, 1);
        drive("R2 down -1.25",   1, 1, 0, 2, 32'hBFA00000, 32'hFFFFFFFE, 0, 1);
        drive("R2 zero -1.25",   1, 1, 0, 3, 32'hBFA00000, 32'hFFFFFFFF, 0, 1);
        drive("R2 code6 -1.25",  1, 1, 0, 6, 32'hBFA00000, 32'hFFFFFFFF, 0, 1);
        drive("R3 3.75 fb4",     1, 1, 4, 3, 32'h40700000, 32'h0000003C, 0, 0);
        drive("R3 0.75 fb1",     1, 1, 1, 0, 32'h3F400000, 32'h00000002, 0, 1);
        drive("R3 fb clamp",     0, 0, 20, 0, 32'h3E800000, 32'h00004000, 0, 0);
        drive("R3 0.5 fb32",     0, 1, 32, 0, 32'h3F000000, 32'h80000000, 0, 0);
        drive("R5 exact 100",    1, 1, 0, 0, 32'h42C80000, 32'h00000064, 0, 0);
        drive("R6 max16",        1, 0, 0, 0, 32'h46FFFE00, 32'h00007FFF, 0, 0);
        drive("R6 over16",       1, 0, 0, 0, 32'h47000000, 32'h00007FFF, 1, 0);
        drive("R6 min16",        1, 0, 0, 0, 32'hC7000000, 32'h00008000, 0, 0);
        drive("R6 under16",      1, 0, 0, 0, 32'hC7000100, 32'h00008000, 1, 0);
        drive("R6 over32",       1, 1, 0, 0, 32'h4F000000, 32'h7FFFFFFF, 1, 0);
        drive("R6 min32",        1, 1, 0, 0, 32'hCF000000, 32'h80000000, 0, 0);
        drive("R6 huge32",       1, 1, 0, 0, 32'h501502F9, 32'h7FFFFFFF, 1, 0);
        drive("R11 round sat",   1, 0, 0, 1, 32'h46FFFF00, 32'h00007FFF, 1, 0);
        drive("R7 neg unsigned", 0, 1, 0, 0, 32'hBF800000, 32'h00000000, 1, 0);
        drive("R7 -0.3 to zero", 0, 1, 0, 3, 32'hBE99999A, 32'h00000000, 0, 1);
        drive("R7 max u16",      0, 0, 0, 0, 32'h477FFF00, 32'h0000FFFF, 0, 0);
        drive("R7 over u16",     0, 0, 0, 0, 32'h47800000, 32'h0000FFFF, 1, 0);
        drive("R7 over u32",     0, 1, 0, 0, 32'h501502F9, 32'hFFFFFFFF, 1, 0);
        drive("R8 nan",          1, 1, 0, 0, 32'h7FC00000, 32'h00000000, 1, 0);
        drive("R8 +inf s16",     1, 0, 0, 0, 32'h7F800000, 32'h00007FFF, 1, 0);
        drive("R8 -inf s32",     1, 1, 0, 0, 32'hFF800000, 32'h80000000, 1, 0);
        drive("R8 -inf u32",     0, 1, 0, 0, 32'hFF800000, 32'h00000000, 1, 0);
        drive("R9 subnormal up", 1, 1, 0, 1, 32'h00000001, 32'h00000000, 0, 0);
        drive("R9 -subn down",   1, 1, 0, 2, 32'h80000001, 32'h00000000, 0, 0);
        drive("R10 -1 s16",      1, 0, 0, 0, 32'hBF800000, 32'h0000FFFF, 0, 0);

        @(negedge clk);
        in_valid   = 1'b0;
        in_operand = 32'h42C80000;
        repeat (3) @(negedge clk);
        check("R1 hold result", {out_result, 2'b00}, {last_res, 2'b00});
        check("R1 idle valid", {33'd0, out_valid}, 34'd0);
        check("R1 queue drained", 34'(sb.size()), 34'd0);
        report();
    end
endmodule